// File: doc/BRIEF.md
# Inverter Gate-Drive Fault Shutdown

This block sits between a three-phase PWM generator and the six gate-drive pads of an inverter. It watches two fault sources: an active-low external gate-kill pin and an active-high overcurrent trip from an on-chip comparator. Each source is brought into the clock domain by a two-flop synchronizer. It then passes through its own saturating deglitch counter. A source that stays active for the programmed number of clocks latches a shutdown. The shutdown forces every gate output to its inactive level, and that level is chosen per output by an active-polarity vector.

From reset the pad drivers are held in high impedance. They stay that way until firmware sets the output-enable bit. A latched fault stays in place until both sources have gone inactive and firmware pulses the clear input. A two-bit source field records which input caused the trip. The filter length is programmable. A floor of 32 clocks always applies, so no pulse shorter than 32 system clocks can trip the block.

Top module: `pwm_trip_guard`

## Requirements
- R1: While `fault_active` is 1, each `pwm_out[i]` equals `~act_hi[i]` (its inactive level). While `fault_active` is 0, `pwm_out` equals `pwm_in`.
- R2: The accept threshold is thr = max(`filt_len`, 32) clocks. A fault level held for at least thr clocks trips the block. A pulse held for fewer than thr clocks, such as 31 clocks at `filt_len`=0, never trips it.
- R3: `fault_active` rises exactly thr+2 clock edges after the fault level is first applied: two synchronizer stages plus thr filter samples. This is 34 clocks with the default floor, and it stays within 100 clocks for any `filt_len` up to 98.
- R4: `pwm_oe` is all zeros (high impedance) from reset. It takes the value of `out_en` on every bit one clock after `out_en` changes, whatever `pwm_in` is.
- R5: A latched fault stays active until `sw_clr` is high on an edge where both synchronized sources are inactive. A clear pulse given while a source is still active is ignored.
- R6: On a trip, `fault_src` captures the cause: bit 0 is gate-kill and bit 1 is overcurrent. The field holds unchanged while the fault is latched, even if the other source trips later. It returns to 0 on clear.
- R7: The gate-kill input is active low (`gk_n`=0 is a fault). The overcurrent input is active high. Each source has its own independent filter.
- R8: After reset, `fault_active` is 0 and `fault_src` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 6 | Gate commands from the PWM generator |
| act_hi | input | 6 | Per-output active polarity; the inactive level is the inverse |
| out_en | input | 1 | Firmware output-enable bit |
| gk_n | input | 1 | External gate-kill, active low |
| oc_trip | input | 1 | Overcurrent comparator output, active high |
| filt_len | input | 8 | Programmed deglitch length in clocks (floor of 32) |
| sw_clr | input | 1 | Software fault clear pulse |
| pwm_out | output | 6 | Gate outputs toward the pads |
| pwm_oe | output | 6 | Pad drive enables; 0 means high impedance |
| fault_active | output | 1 | Latched shutdown flag |
| fault_src | output | 2 | Trip cause: bit 0 gate-kill, bit 1 overcurrent |

## Verification
A fault level applied to either input sets `fault_active` on the thr+2-th rising edge. The bench checks this on the falling edge after thr+1 edges, where the flag must still be 0, and again one edge later, where it must be 1. An output-enable change and an accepted clear each take effect one edge after they are driven. The inactive-level and pass-through values on `pwm_out` follow `fault_active` in the same cycle. All inputs are driven and all outputs sampled on falling edges, half a period away from the registers.

// File: rtl/pwm_trip_guard.sv
module pwm_trip_guard #(
  parameter int FILT_W     = 8,
  parameter int MIN_GLITCH = 32,
  parameter int NOUT       = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NOUT-1:0]   pwm_in,
  input  logic [NOUT-1:0]   act_hi,
  input  logic              out_en,
  input  logic              gk_n,
  input  logic              oc_trip,
  input  logic [FILT_W-1:0] filt_len,
  input  logic              sw_clr,
  output logic [NOUT-1:0]   pwm_out,
  output logic [NOUT-1:0]   pwm_oe,
  output logic              fault_active,
  output logic [1:0]        fault_src
);
  localparam int MW = $clog2(MIN_GLITCH + 1);
  localparam int CW = (FILT_W > MW) ? FILT_W : MW;

  logic [1:0]    raw, s1, s2, trip;
  logic [CW-1:0] thr;
  logic          oe_q;

  assign raw = {oc_trip, ~gk_n};
  assign thr = (CW'(filt_len) < CW'(MIN_GLITCH)) ? CW'(MIN_GLITCH) : CW'(filt_len);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
    end

  for (genvar g = 0; g < 2; g++) begin : g_filt
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)            cnt <= '0;
      else if (!s2[g])       cnt <= '0;
      else if (cnt != '1)    cnt <= cnt + 1'b1;
    assign trip[g] = s2[g] && (cnt >= thr - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fault_active <= 1'b0;
      fault_src    <= '0;
    end else if (!fault_active && |trip) begin
      fault_active <= 1'b1;
      fault_src    <= trip;
    end else if (fault_active && sw_clr && s2 == 2'b00) begin
      fault_active <= 1'b0;
      fault_src    <= '0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) oe_q <= 1'b0;
    else        oe_q <= out_en;

  assign pwm_oe  = {NOUT{oe_q}};
  assign pwm_out = fault_active ? ~act_hi : pwm_in;

  a_r2_rise_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_active) |-> $past(|s2));
  a_r5_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_active) |-> ($past(sw_clr) && $past(s2) == 2'b00));
  a_r6_src_known: assert property (@(posedge clk) disable iff (!rst_n)
    fault_active |-> fault_src != 2'b00);
  a_r6_src_held: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_active && $past(fault_active)) |-> $stable(fault_src));
  a_r4_hiz_until_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(out_en) |-> pwm_oe == '0);
endmodule

// File: tb/pwm_trip_guard_tb.sv
module pwm_trip_guard_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] pwm_in = 6'b110011;
  logic [5:0] act_hi = 6'b101010;
  logic       out_en = 1'b0;
  logic       gk_n = 1'b1;
  logic       oc_trip = 1'b0;
  logic [7:0] filt_len = 8'd0;
  logic       sw_clr = 1'b0;
  logic [5:0] pwm_out, pwm_oe;
  logic       fault_active;
  logic [1:0] fault_src;
  int checks = 0;
  int bad = 0;

  always #4 clk = ~clk;

  pwm_trip_guard dut_i (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .act_hi(act_hi), .out_en(out_en),
    .gk_n(gk_n), .oc_trip(oc_trip), .filt_len(filt_len), .sw_clr(sw_clr),
    .pwm_out(pwm_out), .pwm_oe(pwm_oe), .fault_active(fault_active), .fault_src(fault_src)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_clear();
    sw_clr = 1'b1;
    @(negedge clk);
    sw_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R8 fault after reset", {7'd0, fault_active}, 8'd0);
    chk("R8 src after reset", {6'd0, fault_src}, 8'd0);
    chk("R4 hi-z after reset", {2'd0, pwm_oe}, 8'd0);
  endtask

  task automatic t_enable();
    out_en = 1'b1;
    chk("R4 still hi-z before edge", {2'd0, pwm_oe}, 8'd0);
    edges(1);
    chk("R4 enabled", {2'd0, pwm_oe}, 8'h3f);
    chk("R1 pass-through", {2'd0, pwm_out}, {2'd0, pwm_in});
    pwm_in = 6'b001101;
    #1 chk("R1 pass-through second pattern", {2'd0, pwm_out}, 8'b001101);
  endtask

  task automatic t_short_gk();
    filt_len = 8'd0;
    gk_n = 1'b0;
    repeat (31) @(negedge clk);
    gk_n = 1'b1;
    edges(40);
    chk("R2 31-clock gate-kill ignored", {7'd0, fault_active}, 8'd0);
    chk("R2 output untouched", {2'd0, pwm_out}, {2'd0, pwm_in});
  endtask

  task automatic t_exact32();
    gk_n = 1'b0;
    repeat (32) @(negedge clk);
    gk_n = 1'b1;
    edges(5);
    chk("R2 32-clock gate-kill trips", {7'd0, fault_active}, 8'd1);
    edges(3);
    pulse_clear();
    chk("R5 clear after 32-clock trip", {7'd0, fault_active}, 8'd0);
  endtask

  task automatic t_gk_trip();
    gk_n = 1'b0;
    edges(33);
    chk("R3 not yet at thr+1", {7'd0, fault_active}, 8'd0);
    edges(1);
    chk("R3 R7 gate-kill trips at thr+2", {7'd0, fault_active}, 8'd1);
    chk("R1 inactive levels", {2'd0, pwm_out}, {2'd0, ~act_hi});
    chk("R6 gate-kill source", {6'd0, fault_src}, 8'd1);
    pulse_clear();
    chk("R5 clear ignored while active", {7'd0, fault_active}, 8'd1);
    act_hi = 6'b000111;
    #1 chk("R1 polarity per output", {2'd0, pwm_out}, 8'b111000);
    gk_n = 1'b1;
    edges(3);
    chk("R5 latched after release", {7'd0, fault_active}, 8'd1);
    pulse_clear();
    chk("R5 cleared", {7'd0, fault_active}, 8'd0);
    chk("R6 src cleared", {6'd0, fault_src}, 8'd0);
    chk("R1 pass-through after clear", {2'd0, pwm_out}, {2'd0, pwm_in});
  endtask

  task automatic t_oc_filter();
    filt_len = 8'd50;
    oc_trip = 1'b1;
    repeat (49) @(negedge clk);
    oc_trip = 1'b0;
    edges(60);
    chk("R2 49-clock trip under filt 50 ignored", {7'd0, fault_active}, 8'd0);
    oc_trip = 1'b1;
    edges(51);
    chk("R3 overcurrent not yet at 51", {7'd0, fault_active}, 8'd0);
    edges(1);
    chk("R3 R7 overcurrent trips at 52", {7'd0, fault_active}, 8'd1);
    chk("R6 overcurrent source", {6'd0, fault_src}, 8'd2);
    gk_n = 1'b0;
    edges(60);
    chk("R6 source held after second trip", {6'd0, fault_src}, 8'd2);
    gk_n = 1'b1;
    edges(3);
    pulse_clear();
    chk("R5 clear ignored while overcurrent active", {7'd0, fault_active}, 8'd1);
    oc_trip = 1'b0;
    edges(3);
    pulse_clear();
    chk("R5 cleared after both idle", {7'd0, fault_active}, 8'd0);
  endtask

  task automatic t_disable();
    out_en = 1'b0;
    edges(1);
    chk("R4 back to hi-z", {2'd0, pwm_oe}, 8'd0);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    edges(2);
    t_reset();
    t_enable();
    t_short_gk();
    t_exact32();
    t_gk_trip();
    t_oc_filter();
    t_disable();
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule